// File: doc/BRIEF.md
# Timer Compare Channel

This block is one compare channel of an 8-bit timer/counter. On every timer tick it checks the live count against its active compare value. A hit raises a sticky interrupt flag and gives a one-cycle hit strobe to the counter logic, which uses it for clear-on-compare reload. In the non-PWM waveform modes, a hit also moves the waveform output bit by the selected action: hold, toggle, clear or set. Software can also produce that output effect on demand with a force strobe. A forced event raises no flag and gives no hit strobe.

The waveform mode decides where software writes to the compare value go. In normal and clear-on-compare modes a write lands in the active compare register at once. In every other mode the write goes to a shadow register. The shadow is copied into the active register only on a tick that carries the top or bottom event, and a selector input picks which of the two. This keeps PWM pulses whole. When software writes the counter, the block suppresses a hit on the next timer tick, however many idle cycles pass before that tick.

Top module: `tmr_cmp_chan`

## Requirements
- R1: After reset the flag, the waveform output, the hit strobe and the compare readback are all zero.
- R2: In an unbuffered mode, a compare write is visible on the readback and in matching from the next clock cycle.
- R3: In a buffered mode, a write goes to the shadow and the readback shows the shadow. The active value changes only on a tick with at_top high (load_at_bottom = 0) or with at_bottom high (load_at_bottom = 1). In an unbuffered mode the readback shows the active value.
- R4: When tick_en is high and cnt_val equals the active value, hit is high in that same cycle, and cmp_flag is high from the next cycle.
- R5: Writing flag_clr = 1 clears cmp_flag at the next edge. A hit in the same cycle wins, and the flag stays set.
- R6: In an unbuffered mode a hit changes wave_out by act_sel: 00 hold, 01 toggle, 10 clear, 11 set.
- R7: In an unbuffered mode force_stb applies the act_sel action to wave_out at the next edge. It neither raises hit nor sets cmp_flag.
- R8: In a buffered mode neither force_stb nor a hit changes wave_out.
- R9: A pulse on cnt_wr suppresses a hit on the next tick. This holds even when many cycles without a tick come between.
- R10: wave_out keeps its value when wgm_mode changes.
- R11: Mode 3'b000 and mode 3'b010 are unbuffered. Every other mode code is buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer tick; matches and shadow copies happen only here |
| cnt_val | input | 8 | Live counter value |
| at_top | input | 1 | Counter is at the top of its sequence |
| at_bottom | input | 1 | Counter is at the bottom of its sequence |
| wgm_mode | input | 3 | Waveform mode code |
| load_at_bottom | input | 1 | Shadow copy event: 1 = bottom, 0 = top |
| cmp_wr_en | input | 1 | Software compare write strobe |
| cmp_wr_data | input | 8 | Software compare write data |
| cmp_rd_data | output | 8 | Compare readback (shadow or active) |
| act_sel | input | 2 | Output action code |
| force_stb | input | 1 | Force an output event |
| cnt_wr | input | 1 | Software wrote the counter |
| flag_clr | input | 1 | Write-one-to-clear for the flag |
| hit | output | 1 | Qualified compare hit, same cycle |
| cmp_flag | output | 1 | Sticky compare flag |
| wave_out | output | 1 | Waveform output bit |

## Verification
The hit strobe is combinational on the tick cycle. The bench drives inputs just after a falling edge and samples hit a quarter period later, before the rising edge. The flag, the waveform bit, the active value and the readback after a write are registered once, so they are due one edge after the stimulus. The bench reads them at the next falling edge, after it has dropped the strobes. Buffered writes are checked over several ticks. Hit is observed before and after the top or bottom copy tick, and the suppression after a counter write is observed on a tick placed ten idle cycles later.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_TGL  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_SET  = 2'b11
  } act_e;

  localparam logic [MODE_W-1:0] MODE_NORMAL = 3'b000;
  localparam logic [MODE_W-1:0] MODE_CTC    = 3'b010;

  // Shadowed compare writes for every code except the two plain ones
  function automatic logic mode_buffered(input logic [MODE_W-1:0] m);
    return !((m == MODE_NORMAL) || (m == MODE_CTC));
  endfunction

  // Waveform bit after one output event
  function automatic logic next_wave(input act_e a, input logic cur);
    case (a)
      ACT_TGL: return ~cur;
      ACT_CLR: return 1'b0;
      ACT_SET: return 1'b1;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/tcc_cmp_store.sv
module tcc_cmp_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         buffered,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         copy_ev,
  output logic [W-1:0] active,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_en) shadow_q <= wr_data;
      if (wr_en && !buffered) active_q <= wr_data;
      else if (copy_ev)       active_q <= shadow_q;
    end
  end

  assign active  = active_q;
  assign rd_data = buffered ? shadow_q : active_q;
endmodule

// File: rtl/tcc_match_gate.sv
module tcc_match_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] active,
  input  logic         cnt_wr,
  output logic         hit
);
  logic blk_q;

  // Armed by a counter write, spent by the next tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       blk_q <= 1'b0;
    else if (cnt_wr)  blk_q <= 1'b1;
    else if (tick_en) blk_q <= 1'b0;
  end

  assign hit = tick_en && (cnt_val == active) && !blk_q;
endmodule

// File: rtl/tcc_wave_ctl.sv
module tcc_wave_ctl
  import tcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic buffered,
  input  logic hit,
  input  logic force_stb,
  input  act_e act,
  input  logic flag_clr,
  output logic flag,
  output logic wave
);
  logic flag_q;
  logic wave_q;
  logic out_ev;

  assign out_ev = !buffered && (hit || force_stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      if (hit)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (out_ev)        wave_q <= next_wave(act, wave_q);
    end
  end

  assign flag = flag_q;
  assign wave = wave_q;
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import tcc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [W-1:0]      cnt_val,
  input  logic              at_top,
  input  logic              at_bottom,
  input  logic [MODE_W-1:0] wgm_mode,
  input  logic              load_at_bottom,
  input  logic              cmp_wr_en,
  input  logic [W-1:0]      cmp_wr_data,
  output logic [W-1:0]      cmp_rd_data,
  input  logic [1:0]        act_sel,
  input  logic              force_stb,
  input  logic              cnt_wr,
  input  logic              flag_clr,
  output logic              hit,
  output logic              cmp_flag,
  output logic              wave_out
);
  logic         buffered_w;
  logic         copy_ev_w;
  logic [W-1:0] active_w;
  logic         hit_w;

  assign buffered_w = mode_buffered(wgm_mode);
  assign copy_ev_w  = buffered_w && tick_en &&
                      (load_at_bottom ? at_bottom : at_top);

  tcc_cmp_store #(.W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .buffered(buffered_w),
    .wr_en(cmp_wr_en), .wr_data(cmp_wr_data), .copy_ev(copy_ev_w),
    .active(active_w), .rd_data(cmp_rd_data)
  );

  tcc_match_gate #(.W(W)) u_gate (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_val(cnt_val),
    .active(active_w), .cnt_wr(cnt_wr), .hit(hit_w)
  );

  tcc_wave_ctl u_wave (
    .clk(clk), .rst_n(rst_n), .buffered(buffered_w), .hit(hit_w),
    .force_stb(force_stb), .act(act_e'(act_sel)), .flag_clr(flag_clr),
    .flag(cmp_flag), .wave(wave_out)
  );

  assign hit = hit_w;
endmodule

// File: rtl/tcc_chan_chk.sv
module tcc_chan_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         buffered,
  input logic         copy_ev,
  input logic [W-1:0] active,
  input logic         cmp_wr_en,
  input logic [W-1:0] cmp_wr_data,
  input logic         force_stb,
  input logic         cnt_wr,
  input logic         flag_clr,
  input logic         hit,
  input logic         cmp_flag,
  input logic         wave_out
);
  // R4
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cmp_flag);
  // R9
  cnt_wr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !hit);
  // R7
  force_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && !hit && !cmp_flag) |=> !cmp_flag);
  // R8
  pwm_wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buffered |=> $stable(wave_out));
  // R2
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr_en && !buffered) |=> (active == $past(cmp_wr_data)));
  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buffered && !copy_ev) |=> $stable(active));
  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !hit && cmp_flag) |=> !cmp_flag);
endmodule

bind tmr_cmp_chan tcc_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .buffered(buffered_w), .copy_ev(copy_ev_w),
  .active(active_w), .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
  .force_stb(force_stb), .cnt_wr(cnt_wr), .flag_clr(flag_clr),
  .hit(hit), .cmp_flag(cmp_flag), .wave_out(wave_out)
);

// File: tb/tmr_cmp_chan_bench.sv
module tmr_cmp_chan_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 0, at_top = 0, at_bottom = 0, load_at_bottom = 0;
  logic [7:0] cnt_val = 0, cmp_wr_data = 0;
  logic [2:0] wgm_mode = 0;
  logic       cmp_wr_en = 0, force_stb = 0, cnt_wr = 0, flag_clr = 0;
  logic [1:0] act_sel = 0;
  logic [7:0] cmp_rd_data;
  logic       hit, cmp_flag, wave_out;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tmr_cmp_chan u_tmr_cmp_chan (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_val(cnt_val),
    .at_top(at_top), .at_bottom(at_bottom), .wgm_mode(wgm_mode),
    .load_at_bottom(load_at_bottom), .cmp_wr_en(cmp_wr_en),
    .cmp_wr_data(cmp_wr_data), .cmp_rd_data(cmp_rd_data), .act_sel(act_sel),
    .force_stb(force_stb), .cnt_wr(cnt_wr), .flag_clr(flag_clr),
    .hit(hit), .cmp_flag(cmp_flag), .wave_out(wave_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cmp(input logic [7:0] d);
    cmp_wr_en = 1; cmp_wr_data = d;
    @(negedge clk);
    cmp_wr_en = 0;
  endtask

  task automatic do_tick(input logic [7:0] c, input logic top, input logic bot,
                         output logic h);
    tick_en = 1; cnt_val = c; at_top = top; at_bottom = bot;
    #5 h = hit;
    @(negedge clk);
    tick_en = 0; at_top = 0; at_bottom = 0;
  endtask

  task automatic do_force(output logic h);
    force_stb = 1;
    #5 h = hit;
    @(negedge clk);
    force_stb = 0;
  endtask

  task automatic clr_flag();
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 flag", cmp_flag, 0);
    chk("R1 wave", wave_out, 0);
    chk("R1 hit", hit, 0);
    chk("R1 readback", cmp_rd_data, 0);
  endtask

  task automatic t_direct();
    logic h;
    wgm_mode = 3'b000; act_sel = 2'b00;
    wr_cmp(8'h37);
    chk("R2 readback", cmp_rd_data, 8'h37);
    do_tick(8'h36, 0, 0, h);
    chk("R4 no hit off value", h, 0);
    do_tick(8'h37, 0, 0, h);
    chk("R4 hit", h, 1);
    chk("R4 flag set", cmp_flag, 1);
    chk("R6 hold action", wave_out, 0);
    clr_flag();
    chk("R5 flag cleared", cmp_flag, 0);
    flag_clr = 1;
    do_tick(8'h37, 0, 0, h);
    flag_clr = 0;
    chk("R5 set beats clear", cmp_flag, 1);
    clr_flag();
    wgm_mode = 3'b010;
    wr_cmp(8'h44);
    chk("R11 ctc unbuffered readback", cmp_rd_data, 8'h44);
    do_tick(8'h44, 0, 0, h);
    chk("R2 ctc match", h, 1);
    clr_flag();
  endtask

  task automatic t_actions();
    logic h;
    wgm_mode = 3'b000;
    act_sel = 2'b11; do_tick(8'h44, 0, 0, h);
    chk("R6 set", wave_out, 1);
    act_sel = 2'b10; do_tick(8'h44, 0, 0, h);
    chk("R6 clear", wave_out, 0);
    act_sel = 2'b01; do_tick(8'h44, 0, 0, h);
    chk("R6 toggle up", wave_out, 1);
    do_tick(8'h44, 0, 0, h);
    chk("R6 toggle down", wave_out, 0);
    clr_flag();
  endtask

  task automatic t_force();
    logic h;
    wgm_mode = 3'b000;
    act_sel = 2'b11; do_force(h);
    chk("R7 no hit on force", h, 0);
    chk("R7 force set", wave_out, 1);
    chk("R7 no flag", cmp_flag, 0);
    act_sel = 2'b01; do_force(h);
    chk("R7 force toggle", wave_out, 0);
    act_sel = 2'b00; do_force(h);
    chk("R7 force hold", wave_out, 0);
    act_sel = 2'b11; do_force(h);
    chk("R7 force set again", wave_out, 1);
  endtask

  task automatic t_pwm_buffer();
    logic h;
    wgm_mode = 3'b011; load_at_bottom = 0;
    wr_cmp(8'h90);
    chk("R3 shadow readback", cmp_rd_data, 8'h90);
    do_tick(8'h90, 0, 0, h);
    chk("R3 new value not active", h, 0);
    do_tick(8'h44, 0, 0, h);
    chk("R3 old value still active", h, 1);
    clr_flag();
    do_tick(8'hFF, 1, 0, h);
    do_tick(8'h90, 0, 0, h);
    chk("R3 copied at top", h, 1);
    clr_flag();
    wgm_mode = 3'b001; load_at_bottom = 1;
    wr_cmp(8'h20);
    do_tick(8'hFF, 1, 0, h);
    do_tick(8'h20, 0, 0, h);
    chk("R3 top ignored when bottom selected", h, 0);
    do_tick(8'h00, 0, 1, h);
    do_tick(8'h20, 0, 0, h);
    chk("R3 copied at bottom", h, 1);
    clr_flag();
    wgm_mode = 3'b110;
    wr_cmp(8'h55);
    do_tick(8'h55, 0, 0, h);
    chk("R11 code 110 buffered", h, 0);
    chk("R3 buffered readback", cmp_rd_data, 8'h55);
    wgm_mode = 3'b000;
    #5 chk("R3 unbuffered readback shows active", cmp_rd_data, 8'h20);
    @(negedge clk);
  endtask

  task automatic t_pwm_force();
    logic h;
    wgm_mode = 3'b011;
    act_sel = 2'b01; do_force(h);
    chk("R8 force ignored", wave_out, 1);
    act_sel = 2'b10; do_tick(8'h20, 0, 0, h);
    chk("R8 pwm hit seen", h, 1);
    chk("R8 hit leaves wave", wave_out, 1);
    clr_flag();
  endtask

  task automatic t_mode_keep();
    logic h;
    wgm_mode = 3'b010; idle(3);
    chk("R10 kept into ctc", wave_out, 1);
    wgm_mode = 3'b000; idle(2);
    chk("R10 kept into normal", wave_out, 1);
    act_sel = 2'b10; do_force(h);
    wgm_mode = 3'b111; idle(3);
    chk("R10 low kept into pwm", wave_out, 0);
  endtask

  task automatic t_block();
    logic h;
    wgm_mode = 3'b000; act_sel = 2'b00;
    wr_cmp(8'h60);
    cnt_wr = 1; @(negedge clk); cnt_wr = 0;
    idle(10);
    do_tick(8'h60, 0, 0, h);
    chk("R9 blocked hit", h, 0);
    chk("R9 no flag", cmp_flag, 0);
    do_tick(8'h60, 0, 0, h);
    chk("R9 later tick hits", h, 1);
    clr_flag();
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_actions();
    t_force();
    t_pwm_buffer();
    t_pwm_force();
    t_mode_keep();
    t_block();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule